// File: doc/BRIEF.md
# Banked Effective Address Generator

This unit forms 24-bit effective addresses for a processor whose memory space is split into 256 banks of 64 KiB. A 16-bit offset is paired with an 8-bit bank value. On each construct request the unit takes a 4-bit addressing-mode code and several inputs: the instruction operand, the two index registers, the direct-page base, the data bank and the stack pointer. It registers four results. The first is the effective address. The second is a "dummy" address, which is the page-uncorrected address the bus issues during an extra cycle. The third is a flag that says whether that extra cycle is needed. The fourth is the next value of the stack pointer.

Between construct requests, a step input moves the held address forward or back by one byte for multi-byte transfers. The step changes only the in-bank offset, so the bank byte never changes. An emulation-mode input confines stack traffic to one fixed page. An index-width input narrows both index registers to their low byte before any sum. Decoding, bus sequencing and arithmetic are left to the surrounding core.

Top module: `bank_ea_gen`

## Requirements
- R1: While reset is asserted, and after it is released until the first construct request, every output is zero.
- R2: Mode code 0 (absolute) gives address {data bank, operand[15:0]}. The dummy address equals the address and the extra-cycle flag is 0.
- R3: Mode codes 1/2 (indexed read, X/Y) and 3/4 (indexed write, X/Y) set offset = (operand[15:0] + index) mod 2^16 and bank = data bank. The dummy address is {data bank, operand[15:8], offset[7:0]}. For the read codes the extra flag is 1 only when the dummy and effective addresses differ. For the write codes the extra flag is always 1.
- R4: When the index-width input is 1, bits 15:8 of both index registers are treated as zero in every address sum.
- R5: Mode codes 5 (direct), 6 (direct+X) and 7 (direct+Y) give bank 0 and offset = (direct + operand[7:0] + index) mod 2^16, with no index for code 5. The extra flag is 1 exactly when direct[7:0] is nonzero. The dummy address is {0, direct[15:8], offset[7:0]} for codes 6/7 and equals the address for code 5.
- R6: Mode code 8 (stack relative) gives {0, (stack pointer + operand[7:0]) mod 2^16}, with extra flag 0 and dummy equal to the address.
- R7: Mode code 9 (long) gives operand[23:0]. Mode code 10 (long+X) gives {operand[23:16], (operand[15:0] + X) mod 2^16}. Both give extra flag 0 and dummy equal to the address.
- R8: Mode code 11 (push) with emulation 0 addresses {0, stack pointer} and reports next stack pointer = stack pointer - 1.
- R9: Mode code 12 (pull) with emulation 0 first forms stack pointer + 1, then uses it both as the address offset (bank 0) and as the next stack pointer.
- R10: With emulation 1, push and pull address {0x00, 0x01, byte} and report next stack pointer {0x01, byte}. Only the low byte moves, and it wraps within the page. The input's high byte is ignored.
- R11: A step request with no construct request changes the address offset by +1 (direction 0) or -1 (direction 1), modulo 2^16. The bank byte, dummy address, extra flag and next stack pointer stay unchanged.
- R12: A construct request with a reserved mode code (13 to 15) leaves all outputs unchanged. A construct request takes priority over a simultaneous step.
- R13: Results appear on the clock edge that samples the construct request. For non-stack modes the next stack pointer output equals the input stack pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| build_i | input | 1 | Construct request |
| mode_i | input | 4 | Addressing-mode code |
| operand_i | input | 24 | Instruction operand (up to three bytes) |
| idx_x_i | input | 16 | X index register |
| idx_y_i | input | 16 | Y index register |
| direct_i | input | 16 | Direct-page base |
| dbank_i | input | 8 | Data bank |
| sp_i | input | 16 | Stack pointer |
| emu_i | input | 1 | Emulation mode: stack confined to page one |
| idx_narrow_i | input | 1 | Index registers are 8 bits wide |
| step_i | input | 1 | Advance the held address by one byte |
| step_down_i | input | 1 | Step direction: 0 up, 1 down |
| ea_o | output | 24 | Effective address |
| dummy_o | output | 24 | Uncorrected address for the dummy cycle |
| extra_o | output | 1 | Extra bus cycle needed |
| sp_next_o | output | 16 | Stack pointer after the access |

## Verification
Every result is registered once and then held. A corrupted computation therefore shows at the ports on the cycle right after the construct request, and it stays visible until the next request or step. A wrong comparison between the page-corrected and uncorrected sums flips the extra flag on indexed reads, and only when the index crosses a page. For that reason, directed cases pin both a crossing and a non-crossing. A carry that leaks out of the offset during stepping, or out of the low stack byte in emulation mode, shows up as a changed bank or page byte. Wrap-around corner cases expose it on the first step.

// File: rtl/bea_pkg.sv
`timescale 1ns/1ps
package bea_pkg;
   typedef enum logic [3:0] {
      AM_ABS     = 4'd0,
      AM_ABSX_RD = 4'd1,
      AM_ABSY_RD = 4'd2,
      AM_ABSX_WR = 4'd3,
      AM_ABSY_WR = 4'd4,
      AM_DIR     = 4'd5,
      AM_DIRX    = 4'd6,
      AM_DIRY    = 4'd7,
      AM_STKREL  = 4'd8,
      AM_LONG    = 4'd9,
      AM_LONGX   = 4'd10,
      AM_PUSH    = 4'd11,
      AM_PULL    = 4'd12
   } amode_e;
endpackage

// File: rtl/bea_idx_mask.sv
`timescale 1ns/1ps
module bea_idx_mask #(
   parameter int OFS_W  = 16,
   parameter int PAGE_W = 8
) (
   input  logic [OFS_W-1:0] idx_i,
   input  logic             narrow_i,
   output logic [OFS_W-1:0] idx_o
);
   localparam int HI_W = OFS_W - PAGE_W;

   // Narrow registers contribute only their low byte to address sums (R4)
   assign idx_o = narrow_i ? {{HI_W{1'b0}}, idx_i[PAGE_W-1:0]} : idx_i;
endmodule

// File: rtl/bea_stack_addr.sv
`timescale 1ns/1ps
module bea_stack_addr #(
   parameter int OFS_W       = 16,
   parameter int BANK_W      = 8,
   parameter int PAGE_W      = 8,
   parameter int STACK_PAGE  = 1,
   parameter bit EMU_STACK   = 1'b1
) (
   input  logic [OFS_W+BANK_W-1:0] unused_dummy_i,
   input  logic [OFS_W-1:0]        sp_i,
   input  logic                    emu_i,
   input  logic                    pull_i,
   output logic [OFS_W+BANK_W-1:0] addr_o,
   output logic [OFS_W-1:0]        sp_next_o
);
   localparam int ADDR_W = OFS_W + BANK_W;
   localparam int HI_W   = OFS_W - PAGE_W;
   localparam logic [HI_W-1:0] SPAGE = HI_W'(STACK_PAGE);

   logic [OFS_W-1:0]  moved;
   logic [OFS_W-1:0]  access;
   logic [PAGE_W-1:0] low_moved;
   logic [PAGE_W-1:0] low_access;

   // push: access then decrement; pull: increment then access (R8, R9)
   assign moved      = pull_i ? sp_i + 1'b1 : sp_i - 1'b1;
   assign access     = pull_i ? moved : sp_i;
   assign low_moved  = pull_i ? sp_i[PAGE_W-1:0] + 1'b1 : sp_i[PAGE_W-1:0] - 1'b1;
   assign low_access = pull_i ? low_moved : sp_i[PAGE_W-1:0];

   generate
      if (EMU_STACK) begin : g_emu
         always_comb begin
            if (emu_i) begin
               addr_o    = {{BANK_W{1'b0}}, SPAGE, low_access};
               sp_next_o = {SPAGE, low_moved};
            end else begin
               addr_o    = {{BANK_W{1'b0}}, access};
               sp_next_o = moved;
            end
         end
      end else begin : g_native
         always_comb begin
            addr_o    = {{BANK_W{1'b0}}, access};
            sp_next_o = moved;
         end
      end
   endgenerate

   logic unused_ok;
   assign unused_ok = ^{unused_dummy_i, emu_i};
endmodule

// File: rtl/bea_mode_calc.sv
`timescale 1ns/1ps
module bea_mode_calc
   import bea_pkg::*;
#(
   parameter int OFS_W      = 16,
   parameter int BANK_W     = 8,
   parameter int PAGE_W     = 8,
   parameter int STACK_PAGE = 1,
   parameter bit EMU_STACK  = 1'b1
) (
   input  logic [3:0]              mode_i,
   input  logic [OFS_W+BANK_W-1:0] operand_i,
   input  logic [OFS_W-1:0]        xm_i,
   input  logic [OFS_W-1:0]        ym_i,
   input  logic [OFS_W-1:0]        direct_i,
   input  logic [BANK_W-1:0]       dbank_i,
   input  logic [OFS_W-1:0]        sp_i,
   input  logic                    emu_i,
   output logic                    valid_o,
   output logic [OFS_W+BANK_W-1:0] ea_o,
   output logic [OFS_W+BANK_W-1:0] dummy_o,
   output logic                    extra_o,
   output logic [OFS_W-1:0]        sp_next_o
);
   localparam int ADDR_W = OFS_W + BANK_W;
   localparam int HI_W   = OFS_W - PAGE_W;
   localparam logic [BANK_W-1:0] ZBANK = '0;

   amode_e           md;
   logic [OFS_W-1:0] op_ofs;
   logic [OFS_W-1:0] op_pg;
   logic [BANK_W-1:0] op_bank;
   logic             use_y;
   logic [OFS_W-1:0] idx;
   logic [OFS_W-1:0] abs_sum;
   logic [OFS_W-1:0] dir_sum;
   logic [OFS_W-1:0] dir_idx_sum;
   logic [OFS_W-1:0] rel_sum;
   logic [OFS_W-1:0] long_sum;
   logic [ADDR_W-1:0] abs_ea;
   logic [ADDR_W-1:0] abs_dummy;
   logic             dir_extra;
   logic [ADDR_W-1:0] stk_addr;
   logic [OFS_W-1:0] stk_next;

   assign md      = amode_e'(mode_i);
   assign op_ofs  = operand_i[OFS_W-1:0];
   assign op_pg   = {{HI_W{1'b0}}, operand_i[PAGE_W-1:0]};
   assign op_bank = operand_i[ADDR_W-1:OFS_W];
   assign use_y   = (md == AM_ABSY_RD) || (md == AM_ABSY_WR) || (md == AM_DIRY);
   assign idx     = use_y ? ym_i : xm_i;

   assign abs_sum     = op_ofs + idx;
   assign dir_sum     = direct_i + op_pg;
   assign dir_idx_sum = dir_sum + idx;
   assign rel_sum     = sp_i + op_pg;
   assign long_sum    = op_ofs + xm_i;

   // corrected address and the page it would hit without the carry (R3)
   assign abs_ea    = {dbank_i, abs_sum};
   assign abs_dummy = {dbank_i, op_ofs[OFS_W-1:PAGE_W], abs_sum[PAGE_W-1:0]};
   // direct modes cost a cycle only when the base is not page aligned (R5)
   assign dir_extra = |direct_i[PAGE_W-1:0];

   bea_stack_addr #(
      .OFS_W(OFS_W), .BANK_W(BANK_W), .PAGE_W(PAGE_W),
      .STACK_PAGE(STACK_PAGE), .EMU_STACK(EMU_STACK)
   ) u_stack (
      .unused_dummy_i(operand_i),
      .sp_i          (sp_i),
      .emu_i         (emu_i),
      .pull_i        (md == AM_PULL),
      .addr_o        (stk_addr),
      .sp_next_o     (stk_next)
   );

   always_comb begin
      valid_o   = 1'b1;
      ea_o      = '0;
      dummy_o   = '0;
      extra_o   = 1'b0;
      sp_next_o = sp_i;
      case (md)
         AM_ABS: begin
            ea_o    = {dbank_i, op_ofs};
            dummy_o = {dbank_i, op_ofs};
         end
         AM_ABSX_RD, AM_ABSY_RD: begin
            ea_o    = abs_ea;
            dummy_o = abs_dummy;
            extra_o = (abs_ea != abs_dummy);
         end
         AM_ABSX_WR, AM_ABSY_WR: begin
            ea_o    = abs_ea;
            dummy_o = abs_dummy;
            extra_o = 1'b1;
         end
         AM_DIR: begin
            ea_o    = {ZBANK, dir_sum};
            dummy_o = {ZBANK, dir_sum};
            extra_o = dir_extra;
         end
         AM_DIRX, AM_DIRY: begin
            ea_o    = {ZBANK, dir_idx_sum};
            dummy_o = {ZBANK, direct_i[OFS_W-1:PAGE_W], dir_idx_sum[PAGE_W-1:0]};
            extra_o = dir_extra;
         end
         AM_STKREL: begin
            ea_o    = {ZBANK, rel_sum};
            dummy_o = {ZBANK, rel_sum};
         end
         AM_LONG: begin
            ea_o    = operand_i;
            dummy_o = operand_i;
         end
         AM_LONGX: begin
            ea_o    = {op_bank, long_sum};
            dummy_o = {op_bank, long_sum};
         end
         AM_PUSH, AM_PULL: begin
            ea_o      = stk_addr;
            dummy_o   = stk_addr;
            sp_next_o = stk_next;
         end
         default: valid_o = 1'b0;
      endcase
   end
endmodule

// File: rtl/bank_ea_gen.sv
`timescale 1ns/1ps
module bank_ea_gen
   import bea_pkg::*;
#(
   parameter int OFS_W      = 16,
   parameter int BANK_W     = 8,
   parameter int PAGE_W     = 8,
   parameter int STACK_PAGE = 1,
   parameter bit EMU_STACK  = 1'b1
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    build_i,
   input  logic [3:0]              mode_i,
   input  logic [OFS_W+BANK_W-1:0] operand_i,
   input  logic [OFS_W-1:0]        idx_x_i,
   input  logic [OFS_W-1:0]        idx_y_i,
   input  logic [OFS_W-1:0]        direct_i,
   input  logic [BANK_W-1:0]       dbank_i,
   input  logic [OFS_W-1:0]        sp_i,
   input  logic                    emu_i,
   input  logic                    idx_narrow_i,
   input  logic                    step_i,
   input  logic                    step_down_i,
   output logic [OFS_W+BANK_W-1:0] ea_o,
   output logic [OFS_W+BANK_W-1:0] dummy_o,
   output logic                    extra_o,
   output logic [OFS_W-1:0]        sp_next_o
);
   localparam int ADDR_W = OFS_W + BANK_W;
   localparam int HI_W   = OFS_W - PAGE_W;
   localparam logic [HI_W-1:0] SPAGE = HI_W'(STACK_PAGE);

   generate
      if (PAGE_W < 1 || PAGE_W >= OFS_W) begin : g_bad_page
         $error("bank_ea_gen: PAGE_W must lie between 1 and OFS_W-1");
      end
      if (BANK_W < 1) begin : g_bad_bank
         $error("bank_ea_gen: BANK_W must be at least 1");
      end
   endgenerate

   logic [OFS_W-1:0] idx_raw [2];
   logic [OFS_W-1:0] idx_msk [2];
   assign idx_raw[0] = idx_x_i;
   assign idx_raw[1] = idx_y_i;

   generate
      for (genvar gi = 0; gi < 2; gi++) begin : g_idx
         bea_idx_mask #(.OFS_W(OFS_W), .PAGE_W(PAGE_W)) u_mask (
            .idx_i   (idx_raw[gi]),
            .narrow_i(idx_narrow_i),
            .idx_o   (idx_msk[gi])
         );
      end
   endgenerate

   logic              c_valid;
   logic [ADDR_W-1:0] c_ea;
   logic [ADDR_W-1:0] c_dummy;
   logic              c_extra;
   logic [OFS_W-1:0]  c_spn;

   bea_mode_calc #(
      .OFS_W(OFS_W), .BANK_W(BANK_W), .PAGE_W(PAGE_W),
      .STACK_PAGE(STACK_PAGE), .EMU_STACK(EMU_STACK)
   ) u_calc (
      .mode_i   (mode_i),
      .operand_i(operand_i),
      .xm_i     (idx_msk[0]),
      .ym_i     (idx_msk[1]),
      .direct_i (direct_i),
      .dbank_i  (dbank_i),
      .sp_i     (sp_i),
      .emu_i    (emu_i),
      .valid_o  (c_valid),
      .ea_o     (c_ea),
      .dummy_o  (c_dummy),
      .extra_o  (c_extra),
      .sp_next_o(c_spn)
   );

   logic [OFS_W-1:0] stepped;
   assign stepped = step_down_i ? ea_o[OFS_W-1:0] - 1'b1 : ea_o[OFS_W-1:0] + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ea_o      <= '0;
         dummy_o   <= '0;
         extra_o   <= 1'b0;
         sp_next_o <= '0;
      end else if (build_i) begin
         if (c_valid) begin
            ea_o      <= c_ea;
            dummy_o   <= c_dummy;
            extra_o   <= c_extra;
            sp_next_o <= c_spn;
         end
      end else if (step_i) begin
         ea_o[OFS_W-1:0] <= stepped;
      end
   end

   logic rd_mode, wr_mode, stk_mode, rsv_mode;
   assign rd_mode  = (mode_i == AM_ABSX_RD) || (mode_i == AM_ABSY_RD);
   assign wr_mode  = (mode_i == AM_ABSX_WR) || (mode_i == AM_ABSY_WR);
   assign stk_mode = (mode_i == AM_PUSH) || (mode_i == AM_PULL);
   assign rsv_mode = (mode_i > AM_PULL);

   a_r3_rd_skip: assert property (@(posedge clk) disable iff (!rst_n)
      build_i && rd_mode |=> extra_o == (ea_o != dummy_o));
   a_r3_wr_extra: assert property (@(posedge clk) disable iff (!rst_n)
      build_i && wr_mode |=> extra_o);
   a_r5_dir_extra: assert property (@(posedge clk) disable iff (!rst_n)
      build_i && (mode_i == AM_DIR) |=> extra_o == ($past(direct_i[PAGE_W-1:0]) != '0));
   a_r8_push_next: assert property (@(posedge clk) disable iff (!rst_n)
      build_i && (mode_i == AM_PUSH) && !emu_i |=> sp_next_o == $past(sp_i) - 1'b1);
   a_r10_emu_page: assert property (@(posedge clk) disable iff (!rst_n)
      build_i && stk_mode && emu_i && EMU_STACK |=>
      ea_o[ADDR_W-1:PAGE_W] == {{BANK_W{1'b0}}, SPAGE} && sp_next_o[OFS_W-1:PAGE_W] == SPAGE);
   a_r11_bank_fixed: assert property (@(posedge clk) disable iff (!rst_n)
      step_i && !build_i |=> $stable(ea_o[ADDR_W-1:OFS_W]) && $stable(dummy_o) && $stable(extra_o));
   a_r12_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
      build_i && rsv_mode |=> $stable(ea_o) && $stable(dummy_o) && $stable(extra_o) && $stable(sp_next_o));
endmodule

// File: tb/bank_ea_gen_bench.sv
`timescale 1ns/1ps
module bank_ea_gen_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        build = 1'b0;
   logic [3:0]  mode = '0;
   logic [23:0] opnd = '0;
   logic [15:0] ix = '0, iy = '0, dr = '0, sp = '0;
   logic [7:0]  db = '0;
   logic        emu = 1'b0, nar = 1'b0, step = 1'b0, sdn = 1'b0;
   logic [23:0] ea, dum;
   logic        xtra;
   logic [15:0] spn;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   logic [23:0] e_ea = '0, e_dum = '0;
   logic        e_x = 1'b0;
   logic [15:0] e_sp = '0;

   always #10 clk = ~clk;

   bank_ea_gen u_bank_ea_gen (
      .clk(clk), .rst_n(rst_n), .build_i(build), .mode_i(mode), .operand_i(opnd),
      .idx_x_i(ix), .idx_y_i(iy), .direct_i(dr), .dbank_i(db), .sp_i(sp),
      .emu_i(emu), .idx_narrow_i(nar), .step_i(step), .step_down_i(sdn),
      .ea_o(ea), .dummy_o(dum), .extra_o(xtra), .sp_next_o(spn)
   );

   function automatic string tag(input logic [3:0] m);
      case (m)
         4'd0: return "R2";
         4'd1, 4'd2, 4'd3, 4'd4: return "R3";
         4'd5, 4'd6, 4'd7: return "R5";
         4'd8: return "R6";
         4'd9, 4'd10: return "R7";
         4'd11: return "R8";
         4'd12: return "R9";
         default: return "R12";
      endcase
   endfunction

   // reference: {valid, ea, dummy, extra, next sp}
   function automatic logic [65:0] model(input logic [3:0] m, input logic [23:0] op,
         input logic [15:0] x, input logic [15:0] y, input logic [15:0] d,
         input logic [7:0] bk, input logic [15:0] s, input logic em, input logic n);
      logic [15:0] xi, yi, o, k;
      logic [7:0]  t;
      logic [23:0] a, u;
      logic        f, v;
      logic [15:0] q;
      xi = n ? {8'h00, x[7:0]} : x;
      yi = n ? {8'h00, y[7:0]} : y;
      v = 1'b1; f = 1'b0; q = s; a = '0;
      k = (m == 4'd2 || m == 4'd4 || m == 4'd7) ? yi : xi;
      case (m)
         4'd0: a = {bk, op[15:0]};
         4'd1, 4'd2, 4'd3, 4'd4: begin
            o = op[15:0] + k;
            a = {bk, o};
         end
         4'd5: a = {8'h00, d + {8'h00, op[7:0]}};
         4'd6, 4'd7: a = {8'h00, d + {8'h00, op[7:0]} + k};
         4'd8: a = {8'h00, s + {8'h00, op[7:0]}};
         4'd9: a = op;
         4'd10: a = {op[23:16], op[15:0] + xi};
         4'd11: begin
            if (em) begin a = {16'h0001, s[7:0]}; q = {8'h01, s[7:0] - 8'd1}; end
            else begin a = {8'h00, s}; q = s - 16'd1; end
         end
         4'd12: begin
            if (em) begin t = s[7:0] + 8'd1; a = {16'h0001, t}; q = {8'h01, t}; end
            else begin o = s + 16'd1; a = {8'h00, o}; q = o; end
         end
         default: v = 1'b0;
      endcase
      u = a;
      if (m >= 4'd1 && m <= 4'd4) begin
         u = {bk, op[15:8], a[7:0]};
         f = (m >= 4'd3) ? 1'b1 : (u != a);
      end
      if (m >= 4'd5 && m <= 4'd7) begin
         f = (d[7:0] != 8'h00);
         if (m != 4'd5) u = {8'h00, d[15:8], a[7:0]};
      end
      return {v, a, u, f, q};
   endfunction

   task automatic check(input string req);
      checks++;
      if (ea !== e_ea || dum !== e_dum || xtra !== e_x || spn !== e_sp) begin
         fails++;
         $display("FAIL %s: got ea=%h dummy=%h extra=%b sp=%h, expected ea=%h dummy=%h extra=%b sp=%h",
                  req, ea, dum, xtra, spn, e_ea, e_dum, e_x, e_sp);
      end
   endtask

   task automatic build_op(input logic [3:0] m, input logic [23:0] op, input logic [15:0] x,
         input logic [15:0] y, input logic [15:0] d, input logic [7:0] bk,
         input logic [15:0] s, input logic em, input logic n, input logic with_step,
         input string req);
      logic [65:0] r;
      mode = m; opnd = op; ix = x; iy = y; dr = d; db = bk; sp = s; emu = em; nar = n;
      build = 1'b1; step = with_step; sdn = 1'b0;
      @(negedge clk);
      build = 1'b0; step = 1'b0;
      r = model(m, op, x, y, d, bk, s, em, n);
      if (r[65]) begin
         e_ea = r[64:41]; e_dum = r[40:17]; e_x = r[16]; e_sp = r[15:0];
      end
      check(req);
   endtask

   task automatic do_step(input logic down);
      step = 1'b1; sdn = down;
      @(negedge clk);
      step = 1'b0;
      e_ea = {e_ea[23:16], down ? e_ea[15:0] - 16'd1 : e_ea[15:0] + 16'd1};
      check("R11");
   endtask

   initial begin
      #(200000 * 20);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout, expected completion");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7731));
      repeat (3) @(negedge clk);
      check("R1");
      rst_n = 1'b1;
      @(negedge clk);
      check("R1");

      // R2 absolute
      build_op(4'd0, 24'h77ABCD, 16'h0, 16'h0, 16'h0, 8'h3C, 16'h0, 0, 0, 0, "R2");
      // R3 read with page cross, without, and write forcing the cycle
      build_op(4'd1, 24'h0012F0, 16'h0020, 16'h0, 16'h0, 8'h05, 16'h0, 0, 0, 0, "R3");
      build_op(4'd2, 24'h001200, 16'h0, 16'h0005, 16'h0, 8'h05, 16'h0, 0, 0, 0, "R3");
      build_op(4'd3, 24'h001200, 16'h0005, 16'h0, 16'h0, 8'h05, 16'h0, 0, 0, 0, "R3");
      build_op(4'd1, 24'h00FFFF, 16'h0002, 16'h0, 16'h0, 8'h09, 16'h0, 0, 0, 0, "R3");
      // R4 narrow index drops the high byte
      build_op(4'd4, 24'h001000, 16'h0, 16'hFF80, 16'h0, 8'h01, 16'h0, 0, 1, 0, "R4");
      // R5 direct, aligned and unaligned base
      build_op(4'd5, 24'h000010, 16'h0, 16'h0, 16'h2300, 8'hAA, 16'h0, 0, 0, 0, "R5");
      build_op(4'd6, 24'h0000F0, 16'h0030, 16'h0, 16'h2301, 8'hAA, 16'h0, 0, 0, 0, "R5");
      // R6, R7
      build_op(4'd8, 24'h000004, 16'h0, 16'h0, 16'h0, 8'h11, 16'h01F0, 0, 0, 0, "R6");
      build_op(4'd10, 24'h42FFF0, 16'h0020, 16'h0, 16'h0, 8'h11, 16'h0, 0, 0, 0, "R7");
      // R8, R9 native stack; R10 emulation page wrap
      build_op(4'd11, 24'h0, 16'h0, 16'h0, 16'h0, 8'h11, 16'h0000, 0, 0, 0, "R8");
      build_op(4'd12, 24'h0, 16'h0, 16'h0, 16'h0, 8'h11, 16'hFFFF, 0, 0, 0, "R9");
      build_op(4'd11, 24'h0, 16'h0, 16'h0, 16'h0, 8'h11, 16'h3400, 1, 0, 0, "R10");
      build_op(4'd12, 24'h0, 16'h0, 16'h0, 16'h0, 8'h11, 16'h01FF, 1, 0, 0, "R10");
      // R11 wraps within the bank both ways
      build_op(4'd9, 24'h5AFFFF, 16'h0, 16'h0, 16'h0, 8'h00, 16'h0, 0, 0, 0, "R7");
      do_step(1'b0);
      do_step(1'b1);
      do_step(1'b1);
      // R12 reserved hold, and build wins over step
      build_op(4'd14, 24'h123456, 16'h1, 16'h1, 16'h1, 8'h01, 16'h1, 0, 0, 1, "R12");
      build_op(4'd0, 24'h00FFFF, 16'h0, 16'h0, 16'h0, 8'h20, 16'h1234, 0, 0, 1, "R12");

      // R13 random mix
      for (int i = 0; i < 600; i++) begin
         logic [3:0] m;
         m = 4'($urandom_range(0, 15));
         build_op(m, 24'($urandom), 16'($urandom), 16'($urandom),
                  ($urandom_range(0, 3) == 0) ? {8'($urandom), 8'h00} : 16'($urandom),
                  8'($urandom), 16'($urandom), 1'($urandom), 1'($urandom), 1'b0,
                  (m > 4'd12) ? "R12" : "R13");
         if ($urandom_range(0, 2) == 0) do_step(1'($urandom));
      end

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule